// File: doc/BRIEF.md
# Synchronized Phase-Offset Switching Clock

This block generates the period reference for one converter channel, counting in system-clock cycles. When its enable input rises it looks for an external synchronization clock. If it finds one, every period starts a fixed number of cycles after an external rising edge. If it finds none, it free-runs at a configured period. If a clock that was locked later stops, the block keeps running at the last period it measured. It stays in the mode chosen at enable until enable is lowered and raised again.

A second pulse, delayed within each period, staggers the switching of channels that share an input supply. Its position is one eighth of the active period times a 3-bit index. The index normally comes from the low three bits of the device address, so channels with different addresses take different phases. A management-written value can replace it. A 2-bit status output reports the current mode.

Top module: `sync_phase_clkgen`

## Requirements
- R1: While `enable` is low, `lockState` reads 2'b00 and neither `periodStart` nor `phasePulse` is ever high. After a reset `lockState` is 2'b00.
- R2: On a rising edge of `enable`, the block searches for two consecutive `syncIn` rising edges. If their spacing is at least MIN_PER and at most MAX_PER cycles, `lockState` becomes 2'b10 (locked). Otherwise, or if an edge is missing for more than MAX_PER cycles, `lockState` becomes 2'b01 (internal). During the search `lockState` stays 2'b00.
- R3: In internal mode `periodStart` pulses for one cycle every `cfgPeriod` cycles (`cfgPeriod` >= 2). A new `cfgPeriod` takes effect at the next wrap.
- R4: In locked mode `periodStart` pulses exactly 3 cycles after the `syncIn` level changes from 0 to 1, as seen at the clock edge that samples it. The spacing of the pulses follows the external clock, including changes of its period.
- R5: In locked mode the spacing of the last two external edges is stored. If no edge arrives before the count since the last period start reaches 1.5 times that stored value, the state becomes 2'b11 (holdover). The first holdover `periodStart` comes 1.5×P+1 cycles after the previous one. After that the pulses repeat every P cycles, where P is the stored period.
- R6: `syncIn` has no effect in internal or holdover mode. The mode and the pulse spacing stay unchanged until `enable` falls.
- R7: `phasePulse` pulses once per period, floor(P×k/8) cycles after `periodStart`. Here P is the active period and k is `devAddrLow`. When k=0 it coincides with `periodStart`.
- R8: When `phaseOvrEn` is high, k is taken from `phaseOvrVal` instead of `devAddrLow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel enable; its rising edge starts the clock search |
| syncIn | input | 1 | External synchronization clock (asynchronous, synchronized inside) |
| cfgPeriod | input | CNT_W | Internal switching period in cycles |
| devAddrLow | input | 3 | Low three bits of the device address (phase index) |
| phaseOvrEn | input | 1 | Selects the written phase index |
| phaseOvrVal | input | 3 | Written phase index |
| periodStart | output | 1 | One-cycle pulse at the start of each period |
| phasePulse | output | 1 | One-cycle pulse at the phase-shifted point of each period |
| lockState | output | 2 | 00 off/searching, 01 internal, 10 locked, 11 holdover |

## Verification
Suppose the mode register takes a wrong value, for example locking when it should fall back to internal. `lockState` shows this on the very next cycle, and the spacing of `periodStart` is wrong within one period. A wrong stored period does not show while locked, because the external edges still set the timing. It shows only as a wrong `phasePulse` offset within one period, or as a wrong holdover spacing at the first period after the clock is lost. For that reason the bench checks the offset and the holdover spacing, not only the locked spacing. A corrupted counter shows at once as a `periodStart` spacing that does not match the active period.

// File: rtl/swclk_pkg.sv
package swclk_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_SEEK1 = 3'd1,
    ST_SEEK2 = 3'd2,
    ST_INT   = 3'd3,
    ST_LOCK  = 3'd4,
    ST_HOLD  = 3'd5
  } swclk_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;       // restart the period counter
    logic loadMeas;  // capture the current interval as measured period
    logic freeRun;   // counter wraps at the active period
    logic useMeas;   // active period is the measured one
    logic run;       // pulses may be emitted
  } swclk_strobe_t;

  localparam logic [1:0] LS_OFF  = 2'b00;
  localparam logic [1:0] LS_INT  = 2'b01;
  localparam logic [1:0] LS_LOCK = 2'b10;
  localparam logic [1:0] LS_HOLD = 2'b11;

endpackage

// File: rtl/swclk_datapath.sv
module swclk_datapath
  import swclk_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_PER = 20,
  parameter int MAX_PER = 400,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [IDX_W-1:0] devAddrLow,
  input  logic             phaseOvrEn,
  input  logic [IDX_W-1:0] phaseOvrVal,
  input  swclk_strobe_t    strb,
  output logic             syncRise,
  output logic             seekTimeout,
  output logic             intervalOk,
  output logic             lossHit,
  output logic             periodStart,
  output logic             phasePulse
);

  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_PER);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PER);
  localparam int PROD_W = CNT_W + IDX_W;

  logic syncMeta, syncQ, syncPrev;
  logic [CNT_W-1:0] cnt, measPeriod, activePeriod, interval, phaseTgt;
  logic [CNT_W:0]   lossLimit;
  logic [IDX_W-1:0] phaseIdx;
  logic [PROD_W-1:0] phaseProd;
  logic wrapHit;

  // two-stage synchronizer plus edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncMeta <= 1'b0;
      syncQ    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncMeta <= syncIn;
      syncQ    <= syncMeta;
      syncPrev <= syncQ;
    end
  end
  assign syncRise = syncQ & ~syncPrev;

  assign activePeriod = strb.useMeas ? measPeriod : cfgPeriod;
  assign interval     = cnt + 1'b1;
  assign wrapHit      = (cnt >= activePeriod - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (strb.clr) begin
      cnt <= '0;
    end else if (strb.freeRun && wrapHit) begin
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      measPeriod <= MAX_C;
    end else if (strb.loadMeas) begin
      measPeriod <= interval;
    end
  end

  assign intervalOk  = (interval >= MIN_C) && (interval <= MAX_C);
  assign seekTimeout = (cnt >= MAX_C);
  assign lossLimit   = {1'b0, measPeriod} + {2'b00, measPeriod[CNT_W-1:1]};
  assign lossHit     = ({1'b0, cnt} >= lossLimit);

  // phase point: floor(active period * index / 8)
  assign phaseIdx  = phaseOvrEn ? phaseOvrVal : devAddrLow;
  assign phaseProd = {{IDX_W{1'b0}}, activePeriod} * {{CNT_W{1'b0}}, phaseIdx};
  assign phaseTgt  = phaseProd[PROD_W-1:IDX_W];

  assign periodStart = strb.run && (cnt == '0);
  assign phasePulse  = strb.run && (cnt == phaseTgt);

endmodule

// File: rtl/swclk_ctrl.sv
module swclk_ctrl
  import swclk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          syncRise,
  input  logic          seekTimeout,
  input  logic          intervalOk,
  input  logic          lossHit,
  output swclk_strobe_t strb,
  output logic [1:0]    lockState
);

  swclk_state_t state, nextState;
  logic enPrev, enRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_OFF;
      enPrev <= 1'b0;
    end else begin
      state  <= nextState;
      enPrev <= enable;
    end
  end

  assign enRise = enable & ~enPrev;

  always_comb begin
    nextState = state;
    strb      = '0;
    if (!enable) begin
      nextState = ST_OFF;
      strb.clr  = 1'b1;
    end else begin
      case (state)
        ST_OFF: begin
          strb.clr = 1'b1;
          if (enRise) nextState = ST_SEEK1;
        end
        ST_SEEK1: begin
          if (syncRise) begin
            nextState = ST_SEEK2;
            strb.clr  = 1'b1;
          end else if (seekTimeout) begin
            nextState = ST_INT;
            strb.clr  = 1'b1;
          end
        end
        ST_SEEK2: begin
          if (syncRise) begin
            strb.clr = 1'b1;
            if (intervalOk) begin
              nextState     = ST_LOCK;
              strb.loadMeas = 1'b1;
            end else begin
              nextState = ST_INT;
            end
          end else if (seekTimeout) begin
            nextState = ST_INT;
            strb.clr  = 1'b1;
          end
        end
        ST_INT: begin
          strb.run     = 1'b1;
          strb.freeRun = 1'b1;
        end
        ST_LOCK: begin
          strb.run     = 1'b1;
          strb.useMeas = 1'b1;
          if (syncRise) begin
            strb.clr      = 1'b1;
            strb.loadMeas = intervalOk;
          end else if (lossHit) begin
            nextState = ST_HOLD;
            strb.clr  = 1'b1;
          end
        end
        ST_HOLD: begin
          strb.run     = 1'b1;
          strb.freeRun = 1'b1;
          strb.useMeas = 1'b1;
        end
        default: begin
          nextState = ST_OFF;
          strb.clr  = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_INT:  lockState = LS_INT;
      ST_LOCK: lockState = LS_LOCK;
      ST_HOLD: lockState = LS_HOLD;
      default: lockState = LS_OFF;
    endcase
  end

endmodule

// File: rtl/sync_phase_clkgen.sv
module sync_phase_clkgen
  import swclk_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_PER = 20,
  parameter int MAX_PER = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [2:0]       devAddrLow,
  input  logic             phaseOvrEn,
  input  logic [2:0]       phaseOvrVal,
  output logic             periodStart,
  output logic             phasePulse,
  output logic [1:0]       lockState
);

  swclk_strobe_t strb;
  logic syncRise, seekTimeout, intervalOk, lossHit;

  swclk_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .syncRise   (syncRise),
    .seekTimeout(seekTimeout),
    .intervalOk (intervalOk),
    .lossHit    (lossHit),
    .strb       (strb),
    .lockState  (lockState)
  );

  swclk_datapath #(
    .CNT_W  (CNT_W),
    .MIN_PER(MIN_PER),
    .MAX_PER(MAX_PER),
    .IDX_W  (3)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .syncIn     (syncIn),
    .cfgPeriod  (cfgPeriod),
    .devAddrLow (devAddrLow),
    .phaseOvrEn (phaseOvrEn),
    .phaseOvrVal(phaseOvrVal),
    .strb       (strb),
    .syncRise   (syncRise),
    .seekTimeout(seekTimeout),
    .intervalOk (intervalOk),
    .lossHit    (lossHit),
    .periodStart(periodStart),
    .phasePulse (phasePulse)
  );

endmodule

// File: rtl/sync_phase_clkgen_sva.sv
module sync_phase_clkgen_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [2:0] devAddrLow,
  input logic       phaseOvrEn,
  input logic [2:0] phaseOvrVal,
  input logic       periodStart,
  input logic       phasePulse,
  input logic [1:0] lockState
);

  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (lockState == 2'b00)); // R1

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (lockState == 2'b00) |-> (!periodStart && !phasePulse)); // R1

  AST_INT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lockState == 2'b01 && periodStart) |=> !periodStart); // R3

  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (lockState == 2'b10 && $past(lockState) != 2'b10) |-> periodStart); // R4

  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (lockState == 2'b11 && $past(lockState) == 2'b10) |-> periodStart); // R5

  AST_INT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (lockState == 2'b01 && enable) |=> (lockState == 2'b01)); // R6

  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (lockState == 2'b11 && enable) |=> (lockState == 2'b11)); // R6

  AST_ZERO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!phaseOvrEn && devAddrLow == 3'd0 && periodStart) |-> phasePulse); // R7

  AST_OVR_ZERO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseOvrEn && phaseOvrVal == 3'd0 && periodStart) |-> phasePulse); // R8

endmodule

bind sync_phase_clkgen sync_phase_clkgen_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .devAddrLow (devAddrLow),
  .phaseOvrEn (phaseOvrEn),
  .phaseOvrVal(phaseOvrVal),
  .periodStart(periodStart),
  .phasePulse (phasePulse),
  .lockState  (lockState)
);

// File: tb/sync_phase_clkgen_test.sv
`timescale 1ns/1ps
module sync_phase_clkgen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        syncIn = 1'b0;
  logic [15:0] cfgPeriod = 16'd50;
  logic [2:0]  devAddrLow = 3'd0;
  logic        phaseOvrEn = 1'b0;
  logic [2:0]  phaseOvrVal = 3'd0;
  logic        periodStart, phasePulse;
  logic [1:0]  lockState;

  int total = 0, bad = 0;
  bit done = 0;

  // monitor / sync generator state
  int cyc = 0, lastStart = 0, gap = 0, phaseDelta = -1, alignDelta = -1;
  int startCount = 0, pulseCount = 0, lastSyncRise = -1000;
  bit syncOn = 0;
  int syncPer = 80, ph = 0;

  always #2 clk = ~clk;

  sync_phase_clkgen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .syncIn(syncIn),
    .cfgPeriod(cfgPeriod), .devAddrLow(devAddrLow),
    .phaseOvrEn(phaseOvrEn), .phaseOvrVal(phaseOvrVal),
    .periodStart(periodStart), .phasePulse(phasePulse), .lockState(lockState)
  );

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (periodStart) begin
        gap = cyc - lastStart;
        lastStart = cyc;
        startCount++;
        alignDelta = cyc - lastSyncRise;
      end
      if (phasePulse) phaseDelta = cyc - lastStart;
      if (periodStart || phasePulse) pulseCount++;
      if (syncOn) begin
        syncIn = (ph < syncPer / 2);
        if (ph == 0) lastSyncRise = cyc;
        ph = (ph + 1 >= syncPer) ? 0 : ph + 1;
      end else begin
        syncIn = 1'b0;
        ph = 0;
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitStarts(input int n, input string req);
    int target = startCount + n;
    int lim = 0;
    while (startCount < target && lim < 20000) begin
      step();
      lim++;
    end
    check(startCount >= target, req, "periodStart pulses arrive", startCount, target);
    step();
  endtask

  task automatic tReset();
    rst_n = 1'b0;
    waitCycles(5);
    check(lockState == 2'b00, "R1", "lockState in reset", lockState, 0);
    check(!periodStart && !phasePulse, "R1", "pulses in reset",
          int'(periodStart) + int'(phasePulse), 0);
    rst_n = 1'b1;
    waitCycles(3);
  endtask

  task automatic tInternal();
    cfgPeriod = 16'd50; devAddrLow = 3'd1; phaseOvrEn = 1'b0; syncOn = 0;
    enable = 1'b1;
    waitCycles(450);
    check(lockState == 2'b01, "R2", "no sync -> internal", lockState, 1);
    waitStarts(3, "R3");
    check(gap == 50, "R3", "internal period", gap, 50);
    check(phaseDelta == 6, "R7", "phase idx1 of 50", phaseDelta, 6);
    devAddrLow = 3'd2;
    waitStarts(3, "R7");
    check(phaseDelta == 12, "R7", "phase idx2 of 50", phaseDelta, 12);
    devAddrLow = 3'd0;
    waitStarts(3, "R7");
    check(phaseDelta == 0, "R7", "phase idx0 of 50", phaseDelta, 0);
    phaseOvrEn = 1'b1; phaseOvrVal = 3'd7;
    waitStarts(3, "R8");
    check(phaseDelta == 43, "R8", "override idx7 of 50", phaseDelta, 43);
    phaseOvrEn = 1'b0;
    cfgPeriod = 16'd37;
    waitStarts(3, "R3");
    check(gap == 37, "R3", "new cfgPeriod", gap, 37);
    cfgPeriod = 16'd50;
    waitStarts(2, "R3");
  endtask

  task automatic tIgnoreInInternal();
    syncPer = 80; syncOn = 1;
    waitCycles(400);
    check(lockState == 2'b01, "R6", "sync ignored in internal", lockState, 1);
    waitStarts(3, "R6");
    check(gap == 50, "R6", "internal spacing with sync present", gap, 50);
  endtask

  task automatic tDisable();
    int snap;
    enable = 1'b0;
    waitCycles(3);
    check(lockState == 2'b00, "R1", "disabled state", lockState, 0);
    snap = pulseCount;
    waitCycles(200);
    check(pulseCount == snap, "R1", "no pulses while disabled", pulseCount - snap, 0);
  endtask

  task automatic tLock();
    devAddrLow = 3'd1;
    enable = 1'b1;
    waitCycles(400);
    check(lockState == 2'b10, "R2", "valid sync -> locked", lockState, 2);
    waitStarts(3, "R4");
    check(gap == 80, "R4", "locked spacing", gap, 80);
    check(alignDelta == 3, "R4", "start after sync rise", alignDelta, 3);
    check(phaseDelta == 10, "R7", "phase idx1 of 80", phaseDelta, 10);
    syncPer = 100;
    waitCycles(400);
    waitStarts(3, "R4");
    check(gap == 100, "R4", "locked spacing follows new period", gap, 100);
    check(phaseDelta == 12, "R7", "phase idx1 of 100", phaseDelta, 12);
  endtask

  task automatic tLoss();
    int lim = 0;
    syncOn = 0;
    while (lockState != 2'b11 && lim < 1000) begin
      step();
      lim++;
    end
    check(lockState == 2'b11, "R5", "loss -> holdover", lockState, 3);
    step();
    check(gap == 151, "R5", "first holdover spacing", gap, 151);
    waitStarts(3, "R5");
    check(gap == 100, "R5", "holdover spacing", gap, 100);
    syncPer = 60; syncOn = 1;
    waitCycles(400);
    check(lockState == 2'b11, "R6", "sync ignored in holdover", lockState, 3);
    waitStarts(3, "R6");
    check(gap == 100, "R6", "holdover spacing with sync present", gap, 100);
  endtask

  task automatic tFastSync();
    enable = 1'b0;
    waitCycles(5);
    syncPer = 10;
    enable = 1'b1;
    waitCycles(450);
    check(lockState == 2'b01, "R2", "too-fast sync -> internal", lockState, 1);
    waitStarts(3, "R3");
    check(gap == 50, "R3", "internal period after rejected sync", gap, 50);
  endtask

  task automatic tSlowSync();
    enable = 1'b0;
    waitCycles(5);
    syncPer = 500;
    enable = 1'b1;
    waitCycles(950);
    check(lockState == 2'b01, "R2", "too-slow sync -> internal", lockState, 1);
    enable = 1'b0;
    syncOn = 0;
    waitCycles(5);
  endtask

  initial begin
    #600000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tReset();
    tInternal();
    tIgnoreInInternal();
    tDisable();
    tLock();
    tLoss();
    tFastSync();
    tSlowSync();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule